// File: doc/BRIEF.md
# Vectored Interrupt Controller with Shared Multiple-Source Vector

This block collects 32 level-sensitive request lines from peripherals and turns them into two signals for a processor core: an 8-bit vector bus and a separate non-maskable interrupt (NMI) wire. Lines 1 to 29 are maskable. Lines 30 and 31 are non-maskable. Line 0 has no function. Software programs a 32-bit enable mask and reads back three status words through a small word-addressed register port: raw, masked and NMI.

The block does not pick a winner among maskable sources. When exactly one enabled source is pending, the vector names that source. When two or more are pending, the vector takes a fixed "multiple" code and software scans the masked status word to set its own priority. There is no acknowledge: every status bit follows its line level.

The vector encoder is a three-state machine. `VS_NONE` means nothing enabled is pending. `VS_ONE` means exactly one is pending. `VS_MANY` means two or more are pending. From every state the machine can move to any state, including its own, at each clock. The next state depends only on the count of pending enabled sources after that clock edge: zero leads to `VS_NONE`, one to `VS_ONE`, and more than one to `VS_MANY`. The index of the single source is registered beside the state.

Top module: `vic_core`

## Requirements
- R1: While reset is asserted, and right after it, the mask, raw, masked and NMI status words read zero, `vec_out` is 0 and `nmi_out` is 0, whatever the line levels are.
- R2: Word offset 0 holds the mask. A write with all four byte enables set stores the whole 32-bit word, and a read returns it unchanged.
- R3: A write to any offset other than 0 has no effect on any register. So does a write to offset 0 with any byte enable clear.
- R4: Offset 1 is the raw status. Bit n-1 follows line n for n in 1..29. Line 0 affects nothing, and raw bits 29..31 read 0.
- R5: Offset 2 reads the raw status ANDed bitwise with the mask.
- R6: `vec_out` is 0x00 when the masked status is zero.
- R7: When exactly masked bit i is set, `vec_out` is 0x31 + i.
- R8: When two or more masked bits are set, `vec_out` is 0x30, wherever those bits are.
- R9: Offset 3 is the NMI status. Bits 30 and 31 follow lines 30 and 31, all other bits read 0, and the mask has no effect on them.
- R10: `nmi_out` is 1 exactly when the NMI status word is nonzero.
- R11: Offset 4 and offsets 5 to 7 always read zero.
- R12: `vec_out`, `nmi_out` and the status words change at the first rising clock edge after a line or mask change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_be | input | 4 | Byte enables; only all-ones writes take effect |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from registers |
| vec_out | output | 8 | Interrupt vector; 0 means no request |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The bench goes after the mapping boundaries. If line 29 lands in the wrong bit, the vector comes out as something other than 0x4D. If line 0 were counted, a quiet system would report a vector. The bench also checks that two sources far apart give 0x30 and not the lowest index, since a priority encoder would fail there. It checks that masking one of two pending sources gives that source's single vector, which a design that counts raw bits instead of masked bits gets wrong. Partial-width and wrong-offset writes are checked to leave the mask untouched. Sampling just before the clock edge catches a design whose outputs are combinational or one cycle late.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int LINES_DEF  = 32;
    localparam int NMI_LO_DEF = 30;
    localparam int VEC_W_DEF  = 8;
    localparam int ADDR_W     = 3;
    localparam logic [7:0] VEC_MULTI_DEF = 8'h30;

    typedef enum logic [1:0] {
        VS_NONE = 2'd0,
        VS_ONE  = 2'd1,
        VS_MANY = 2'd2
    } vec_state_e;

    typedef enum logic [ADDR_W-1:0] {
        OFF_MASK   = 3'd0,
        OFF_RAW    = 3'd1,
        OFF_MASKED = 3'd2,
        OFF_NMI    = 3'd3,
        OFF_SPARE  = 3'd4
    } reg_off_e;
endpackage

// File: rtl/vic_capture.sv
module vic_capture
    import vic_pkg::*;
#(
    parameter int LINES  = LINES_DEF,
    parameter int NMI_LO = NMI_LO_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    output logic [LINES-1:0] raw_next,
    output logic [LINES-1:0] raw_q,
    output logic [LINES-1:0] nmi_q,
    output logic             nmi_out_q
);
    localparam int RAW_N = NMI_LO - 1;

    logic [LINES-1:0] nmi_next;
    logic             unused_line0;

    assign unused_line0 = lines[0];

    // line n+1 feeds raw bit n; upper lines feed the NMI word in place
    for (genvar gi = 0; gi < LINES; gi++) begin : g_map
        if (gi < RAW_N) begin : g_raw
            assign raw_next[gi] = lines[gi+1];
        end else begin : g_raw_zero
            assign raw_next[gi] = 1'b0;
        end
        if (gi >= NMI_LO) begin : g_nmi
            assign nmi_next[gi] = lines[gi];
        end else begin : g_nmi_zero
            assign nmi_next[gi] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q     <= '0;
            nmi_q     <= '0;
            nmi_out_q <= 1'b0;
        end else begin
            raw_q     <= raw_next;
            nmi_q     <= nmi_next;
            nmi_out_q <= |nmi_next;
        end
    end
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int LINES = LINES_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [LINES/8-1:0]     be,
    input  logic [LINES-1:0]       wdata,
    input  logic [LINES-1:0]       raw_q,
    input  logic [LINES-1:0]       nmi_q,
    output logic [LINES-1:0]       mask_q,
    output logic [LINES-1:0]       mask_next,
    output logic [LINES-1:0]       rdata
);
    logic     full_wr;
    reg_off_e off;

    assign off     = reg_off_e'(addr);
    assign full_wr = wr && (off == OFF_MASK) && (&be);

    always_comb begin
        mask_next = full_wr ? wdata : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_next;
    end

    always_comb begin
        rdata = '0;
        case (off)
            OFF_MASK:   rdata = mask_q;
            OFF_RAW:    rdata = raw_q;
            OFF_MASKED: rdata = raw_q & mask_q;
            OFF_NMI:    rdata = nmi_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/vic_vector_fsm.sv
module vic_vector_fsm
    import vic_pkg::*;
#(
    parameter int               LINES     = LINES_DEF,
    parameter int               VEC_W     = VEC_W_DEF,
    parameter logic [VEC_W-1:0] VEC_MULTI = VEC_MULTI_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_next,
    input  logic [LINES-1:0] mask_next,
    output logic [VEC_W-1:0] vec
);
    localparam int IDX_W = $clog2(LINES);
    localparam int CNT_W = $clog2(LINES + 1);

    vec_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [LINES-1:0] pend;
    logic [CNT_W-1:0] cnt;
    logic             found;

    assign pend = raw_next & mask_next;

    always_comb begin
        cnt   = '0;
        idx_d = '0;
        found = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (pend[i]) begin
                cnt = cnt + CNT_W'(1);
                if (!found) begin
                    idx_d = IDX_W'(i);
                    found = 1'b1;
                end
            end
        end
        if (cnt == '0)              state_d = VS_NONE;
        else if (cnt == CNT_W'(1))  state_d = VS_ONE;
        else                        state_d = VS_MANY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VS_NONE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        unique case (state_q)
            VS_NONE: vec = '0;
            VS_ONE:  vec = VEC_MULTI + VEC_W'(1) + VEC_W'(idx_q);
            VS_MANY: vec = VEC_MULTI;
            default: vec = '0;
        endcase
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int               LINES     = LINES_DEF,
    parameter int               NMI_LO    = NMI_LO_DEF,
    parameter int               VEC_W     = VEC_W_DEF,
    parameter logic [VEC_W-1:0] VEC_MULTI = VEC_MULTI_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINES-1:0]    irq_lines,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [LINES/8-1:0]  reg_be,
    input  logic [LINES-1:0]    reg_wdata,
    output logic [LINES-1:0]    reg_rdata,
    output logic [VEC_W-1:0]    vec_out,
    output logic                nmi_out
);
    logic [LINES-1:0] raw_next, raw_q, nmi_q, mask_q, mask_next;

    vic_capture #(.LINES(LINES), .NMI_LO(NMI_LO)) u_cap (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines),
        .raw_next(raw_next), .raw_q(raw_q), .nmi_q(nmi_q), .nmi_out_q(nmi_out)
    );

    vic_regfile #(.LINES(LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .be(reg_be),
        .wdata(reg_wdata), .raw_q(raw_q), .nmi_q(nmi_q),
        .mask_q(mask_q), .mask_next(mask_next), .rdata(reg_rdata)
    );

    vic_vector_fsm #(.LINES(LINES), .VEC_W(VEC_W), .VEC_MULTI(VEC_MULTI)) u_vec (
        .clk(clk), .rst_n(rst_n), .raw_next(raw_next), .mask_next(mask_next),
        .vec(vec_out)
    );
endmodule

// File: rtl/vic_core_sva.sv
module vic_core_sva
    import vic_pkg::*;
#(
    parameter int               LINES     = LINES_DEF,
    parameter int               NMI_LO    = NMI_LO_DEF,
    parameter int               VEC_W     = VEC_W_DEF,
    parameter logic [VEC_W-1:0] VEC_MULTI = VEC_MULTI_DEF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LINES-1:0]   irq_lines,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [LINES/8-1:0] reg_be,
    input logic [LINES-1:0]   raw_q,
    input logic [LINES-1:0]   mask_q,
    input logic [LINES-1:0]   nmi_q,
    input logic [VEC_W-1:0]   vec_out,
    input logic               nmi_out
);
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == '0 && (&reg_be)) |=> $stable(mask_q));

    a_r4_raw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> raw_q[NMI_LO-2:0] == $past(irq_lines[NMI_LO-1:1]));

    a_r6_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & mask_q) == '0) |-> (vec_out == '0));

    a_r7_single_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(raw_q & mask_q) == 1) |-> (vec_out > VEC_MULTI));

    a_r8_multi_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(raw_q & mask_q) > 1) |-> (vec_out == VEC_MULTI));

    a_r10_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_q != '0) |-> nmi_out);

    a_r10_nmi_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_q == '0) |-> !nmi_out);
endmodule

bind vic_core vic_core_sva #(
    .LINES(LINES), .NMI_LO(NMI_LO), .VEC_W(VEC_W), .VEC_MULTI(VEC_MULTI)
) u_sva (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_be(reg_be), .raw_q(raw_q), .mask_q(mask_q),
    .nmi_q(nmi_q), .vec_out(vec_out), .nmi_out(nmi_out)
);

// File: tb/vic_core_tb_top.sv
`timescale 1ns/100ps
module vic_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  vec_out;
    logic        nmi_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vic_core dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .vec_out(vec_out), .nmi_out(nmi_out)
    );

    // {lines, mask, expected vector, expected nmi}
    localparam logic [72:0] TBL [0:10] = '{
        {32'h0000_0000, 32'hFFFF_FFFF, 8'h00, 1'b0},
        {32'h0000_0002, 32'hFFFF_FFFF, 8'h31, 1'b0},
        {32'h2000_0000, 32'hFFFF_FFFF, 8'h4D, 1'b0},
        {32'h0000_0006, 32'hFFFF_FFFF, 8'h30, 1'b0},
        {32'h0000_0006, 32'h0000_0002, 8'h32, 1'b0},
        {32'h0000_0006, 32'h0000_0000, 8'h00, 1'b0},
        {32'h0000_0001, 32'hFFFF_FFFF, 8'h00, 1'b0},
        {32'h4000_0000, 32'h0000_0000, 8'h00, 1'b1},
        {32'h8000_0002, 32'hFFFF_FFFF, 8'h31, 1'b1},
        {32'h2000_0002, 32'hFFFF_FFFF, 8'h30, 1'b0},
        {32'h0010_0000, 32'h0008_0000, 8'h44, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, l, m;
        // R1: reset holds everything at zero even with lines high
        irq_lines = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 vec", {24'h0, vec_out}, 32'h0);
        chk("R1 nmi", {31'h0, nmi_out}, 32'h0);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 32'h0);
        end
        @(negedge clk);
        irq_lines = '0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 vec after release", {24'h0, vec_out}, 32'h0);

        // table walk: R2 R4 R5 R6 R7 R8 R9 R10
        for (int k = 0; k < 11; k++) begin
            l = TBL[k][72:41];
            m = TBL[k][40:9];
            wr(3'd0, 4'hF, m);
            irq_lines = l;
            @(posedge clk); #1;
            chk($sformatf("R6/R7/R8 vec row %0d", k), {24'h0, vec_out}, {24'h0, TBL[k][8:1]});
            chk($sformatf("R10 nmi row %0d", k), {31'h0, nmi_out}, {31'h0, TBL[k][0]});
            rd(3'd0, v); chk("R2 mask readback", v, m);
            rd(3'd1, v); chk("R4 raw", v, {3'b000, l[29:1]});
            rd(3'd2, v); chk("R5 masked", v, {3'b000, l[29:1]} & m);
            rd(3'd3, v); chk("R9 nmi status", v, l & 32'hC000_0000);
        end

        // R3: wrong offsets and partial writes leave the mask alone
        wr(3'd0, 4'hF, 32'h1234_5678);
        wr(3'd1, 4'hF, 32'hFFFF_FFFF);
        wr(3'd2, 4'hF, 32'hFFFF_FFFF);
        wr(3'd0, 4'h3, 32'h0000_0000);
        wr(3'd0, 4'h7, 32'hFFFF_FFFF);
        @(posedge clk); #1;
        rd(3'd0, v); chk("R3 mask after ignored writes", v, 32'h1234_5678);
        rd(3'd1, v); chk("R3 raw untouched", v, {3'b000, irq_lines[29:1]});

        // R11: spare and unmapped offsets read zero
        for (int a = 4; a < 8; a++) begin
            rd(3'(a), v);
            chk("R11 spare read", v, 32'h0);
        end

        // R12: outputs change only at the clock edge
        wr(3'd0, 4'hF, 32'hFFFF_FFFF);
        irq_lines = '0;
        @(posedge clk); #1;
        @(negedge clk);
        irq_lines = 32'h4000_0008;
        #1;
        chk("R12 vec before edge", {24'h0, vec_out}, 32'h0);
        chk("R12 nmi before edge", {31'h0, nmi_out}, 32'h0);
        @(posedge clk); #1;
        chk("R12 vec after edge", {24'h0, vec_out}, 32'h33);
        chk("R12 nmi after edge", {31'h0, nmi_out}, 32'h1);

        // R9: mask does not affect NMI
        wr(3'd0, 4'hF, 32'h0);
        @(posedge clk); #1;
        chk("R9 nmi with zero mask", {31'h0, nmi_out}, 32'h1);
        chk("R6 vec with zero mask", {24'h0, vec_out}, 32'h0);

        // R4: line 0 alone changes nothing
        @(negedge clk);
        irq_lines = 32'h0000_0001;
        @(posedge clk); #1;
        rd(3'd1, v); chk("R4 line0 raw", v, 32'h0);
        rd(3'd3, v); chk("R4 line0 nmi", v, 32'h0);

        finish_run();
    end
endmodule